// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter with Cascade Outputs

This block is a synchronous binary counter, four bits wide by default, that steps up or down by one on each rising clock edge while its active-low enable is asserted. A direction input picks the sense of the count. An active-low preset input forces the count to the parallel data word at once, whatever the clock is doing. The preset wins over both reset and counting.

Two outputs support chaining. The terminal flag is a level that is high while the count sits at its last value in the current direction. The ripple strobe is an active-low pulse that covers the low half of the clock at terminal count while counting is enabled. With a shared clock, a wider counter is built by wiring each stage's ripple strobe to the next stage's enable. Enable and direction are captured by a latch that is open while the clock is low. The edge therefore acts on the values that stood through the low phase. The strobe of one stage, which is itself only low during that phase, is taken cleanly by the next stage.

Top module: `ud_counter4`

## Requirements
- R1: With `down_up` = 0 and `en_n` low, each rising edge of `clk` adds one to `q`, and 15 wraps to 0.
- R2: With `down_up` = 1 and `en_n` low, each rising edge subtracts one from `q`, and 0 wraps to 15.
- R3: With `en_n` high, `q` keeps its value across rising edges.
- R4: While `load_n` is low, `q` equals `d` without waiting for a clock edge, in either clock phase. This has priority over counting and over `rst`. `d` is held steady while `load_n` is low.
- R5: `max_min` is 1 exactly when `q` is 15 with `down_up` = 0, or `q` is 0 with `down_up` = 1, whatever the level of `en_n`.
- R6: `rco_n` is 0 only while `clk` is low, `max_min` is 1 and `en_n` is low. Otherwise it is 1.
- R7: `rst` high at a rising edge, with `load_n` high, sets `q` to 0 even while counting is enabled.
- R8: `en_n` and `down_up` are acted on as they stand during the low clock phase before an edge. A change made while `clk` is high takes effect at the next rising edge.
- R9: Two instances on one clock, with the lower stage's `rco_n` driving the upper stage's `en_n`, form an 8-bit counter `{upper q, lower q}`. It steps through every value from 0 to 255 and back to 0 when counting up, and through 0 to 255 and downward when counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| en_n | input | 1 | Count enable, active low |
| down_up | input | 1 | Direction: 0 counts up, 1 counts down |
| load_n | input | 1 | Asynchronous preset, active low |
| d | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| max_min | output | 1 | Terminal-count level for the present direction |
| rco_n | output | 1 | Active-low cascade strobe during the clock low phase |

## Verification
The preset and the counting step can land in the same cycle. The bench provokes this by dropping `load_n` in the low phase and in the high phase between two enabled edges, and by holding it low across an edge while counting and reset are both requested. Each case is judged on `q` while the preset is active and again at the edge after release, where the count must continue from `d`. The terminal strobe and a count step also coincide in the cascade. There, each upper-stage step has to occur on the same edge that wraps the lower stage.

// File: rtl/ud_pkg.sv
package ud_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Controls as captured during the low clock phase
    typedef struct packed {
        logic hold;
        dir_e dir;
    } ctl_t;

    // Terminal condition for the current direction
    function automatic logic at_terminal(input logic all_ones,
                                         input logic all_zero,
                                         input dir_e dir);
        return (dir == DIR_UP) ? all_ones : all_zero;
    endfunction

endpackage

// File: rtl/ud_ctl_latch.sv
module ud_ctl_latch
    import ud_pkg::*;
(
    input  logic clk,
    input  logic en_n,
    input  logic down_up,
    output ctl_t ctl
);

    // Transparent while clk is low, closed while high
    always_latch begin
        if (!clk) begin
            ctl.hold = en_n;
            ctl.dir  = dir_e'(down_up);
        end
    end

endmodule

// File: rtl/ud_step.sv
module ud_step
    import ud_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  dir_e             dir,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        if (dir == DIR_UP) nxt = cur + ONE;
        else               nxt = cur - ONE;
    end

endmodule

// File: rtl/ud_term.sv
module ud_term
    import ud_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             en_n,
    input  dir_e             dir,
    input  logic [WIDTH-1:0] cnt,
    output logic             max_min,
    output logic             rco_n
);

    logic all_ones;
    logic all_zero;

    assign all_ones = &cnt;
    assign all_zero = ~|cnt;
    assign max_min  = at_terminal(all_ones, all_zero, dir);
    assign rco_n    = ~(max_min & ~en_n & ~clk);

endmodule

// File: rtl/ud_counter4.sv
module ud_counter4
    import ud_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic             down_up,
    input  logic             load_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             max_min,
    output logic             rco_n
);

    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
    localparam logic [WIDTH-1:0] TOP_CODE = {WIDTH{1'b1}};

    ctl_t             ctl_lat;
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] cnt_nxt;
    dir_e             dir_now;

    ud_ctl_latch u_lat (
        .clk     (clk),
        .en_n    (en_n),
        .down_up (down_up),
        .ctl     (ctl_lat)
    );

    ud_step #(.WIDTH(WIDTH)) u_step (
        .cur (cnt),
        .dir (ctl_lat.dir),
        .nxt (cnt_nxt)
    );

    // Preset is asynchronous and outranks reset and counting
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)            cnt <= d;
        else if (rst)           cnt <= '0;
        else if (!ctl_lat.hold) cnt <= cnt_nxt;
    end

    assign dir_now = dir_e'(down_up);

    ud_term #(.WIDTH(WIDTH)) u_term (
        .clk     (clk),
        .en_n    (en_n),
        .dir     (dir_now),
        .cnt     (cnt),
        .max_min (max_min),
        .rco_n   (rco_n)
    );

    assign q = cnt;

    // Marks that a preset occurred since the previous edge (for checks)
    logic ld_hit;
    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n) ld_hit <= 1'b1;
        else         ld_hit <= 1'b0;
    end

    // R1
    count_up_chk: assert property (@(posedge clk)
        (load_n && !rst && !ctl_lat.hold && ctl_lat.dir == DIR_UP)
        |=> (ld_hit || cnt == $past(cnt) + ONE));

    // R2
    count_down_chk: assert property (@(posedge clk)
        (load_n && !rst && !ctl_lat.hold && ctl_lat.dir == DIR_DOWN)
        |=> (ld_hit || cnt == $past(cnt) - ONE));

    // R3
    inhibit_hold_chk: assert property (@(posedge clk)
        (load_n && !rst && ctl_lat.hold) |=> (ld_hit || $stable(cnt)));

    // R4
    preset_value_chk: assert property (@(posedge clk)
        !load_n |-> (q == d));

    // R5
    term_up_chk: assert property (@(posedge clk) disable iff (rst)
        (down_up == 1'b0 && q == TOP_CODE) |-> max_min);

    // R6
    strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        (max_min && !en_n) |-> !rco_n);

    // R6
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !max_min |-> rco_n);

    // R7
    sync_clear_chk: assert property (@(posedge clk)
        (rst && load_n) |=> (ld_hit || cnt == '0));

endmodule

// File: tb/sim_ud_counter4.sv
module sim_ud_counter4;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b1;
    logic       down_up = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] d0 = 4'd0;
    logic [3:0] d1 = 4'd0;
    logic [3:0] q0, q1;
    logic       mm0, mm1, rco0, rco1;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    ud_counter4 #(.WIDTH(4)) u0 (
        .clk (clk), .rst (rst), .en_n (en_n), .down_up (down_up),
        .load_n (load_n), .d (d0), .q (q0), .max_min (mm0), .rco_n (rco0)
    );

    // Upper stage of the cascade, enabled by the lower stage strobe
    ud_counter4 #(.WIDTH(4)) u1 (
        .clk (clk), .rst (rst), .en_n (rco0), .down_up (down_up),
        .load_n (load_n), .d (d1), .q (q1), .max_min (mm1), .rco_n (rco1)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Rising edge, then 2 units into the high phase
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Preset pulse placed in the low phase following the current high phase
    task automatic preset(input logic [3:0] lo, input logic [3:0] hi);
        @(negedge clk);
        #1;
        d0 = lo; d1 = hi; load_n = 1'b0;
        #1;
        load_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        tick(); tick();
        chk("R7 reset value", q0, 0);
        chk("R5 flag at reset", mm0, 0);
        chk("R6 strobe idle", rco0, 1);
        rst = 1'b0;
        preset(4'd6, 4'd0);
        en_n = 1'b0;
        tick();
        rst = 1'b1;
        tick();
        chk("R7 reset beats counting", q0, 0);
        rst = 1'b0;
        en_n = 1'b1;
    endtask

    task automatic t_count_up();
        int exp;
        down_up = 1'b0;
        preset(4'd12, 4'd0);
        chk("R4 preset value", q0, 12);
        exp = 12;
        tick();
        en_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            exp = (exp + 1) % 16;
            chk("R1 up step", q0, exp);
        end
        chk("R1 wrap 15 to 0 reached", q0, 2);
        en_n = 1'b1;
    endtask

    task automatic t_count_down();
        int exp;
        down_up = 1'b1;
        preset(4'd2, 4'd0);
        exp = 2;
        tick();
        en_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            exp = (exp + 15) % 16;
            chk("R2 down step", q0, exp);
        end
        chk("R2 wrap 0 to 15 reached", q0, 13);
        en_n = 1'b1;
        down_up = 1'b0;
    endtask

    task automatic t_inhibit();
        preset(4'd7, 4'd0);
        tick();
        en_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 hold while disabled", q0, 7);
        end
        // R8: enable changed in the high phase acts at the next edge
        en_n = 1'b0;
        chk("R8 no change before edge", q0, 7);
        tick();
        chk("R8 counts at next edge", q0, 8);
        en_n = 1'b1;
        tick();
        chk("R8 stop at next edge", q0, 8);
    endtask

    task automatic t_flags();
        down_up = 1'b0;
        preset(4'd15, 4'd0);
        tick();
        en_n = 1'b1;
        chk("R5 flag up at 15 disabled", mm0, 1);
        #5;
        chk("R6 strobe idle when disabled", rco0, 1);
        tick();
        en_n = 1'b0;
        chk("R6 strobe idle clk high", rco0, 1);
        #5;
        chk("R6 strobe low in low phase", rco0, 0);
        tick();
        chk("R1 wrap to 0", q0, 0);
        en_n = 1'b1;
        chk("R5 flag low at 0 up", mm0, 0);
        down_up = 1'b1;
        #1;
        chk("R5 flag at 0 down", mm0, 1);
        #5;
        chk("R6 strobe idle en high", rco0, 1);
        down_up = 1'b0;
        tick();
    endtask

    task automatic t_load_async();
        preset(4'd1, 4'd0);
        tick();
        en_n = 1'b0;
        // low-phase preset between enabled edges
        @(negedge clk);
        #1;
        d0 = 4'd9; load_n = 1'b0;
        #1;
        chk("R4 preset in low phase", q0, 9);
        #1;
        load_n = 1'b1;
        tick();
        chk("R4 count resumes from preset", q0, 10);
        // high-phase preset
        #1;
        d0 = 4'd3; load_n = 1'b0;
        #1;
        chk("R4 preset in high phase", q0, 3);
        load_n = 1'b1;
        tick();
        chk("R4 count after high-phase preset", q0, 4);
        // preset held across an edge with counting and reset requested
        d0 = 4'd11; load_n = 1'b0; rst = 1'b1;
        tick();
        chk("R4 preset beats count and reset", q0, 11);
        rst = 1'b0;
        load_n = 1'b1;
        en_n = 1'b1;
        tick();
        chk("R4 hold after release", q0, 11);
    endtask

    task automatic t_cascade();
        int exp;
        down_up = 1'b0;
        preset(4'd0, 4'd0);
        tick();
        en_n = 1'b0;
        exp = 0;
        for (int i = 0; i < 257; i++) begin
            tick();
            exp = (exp + 1) % 256;
            chk("R9 cascade up", {q1, q0}, exp);
        end
        en_n = 1'b1;
        down_up = 1'b1;
        preset(4'd3, 4'd1);
        exp = 19;
        tick();
        en_n = 1'b0;
        for (int i = 0; i < 24; i++) begin
            tick();
            exp = (exp + 255) % 256;
            chk("R9 cascade down", {q1, q0}, exp);
        end
        en_n = 1'b1;
        down_up = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_count_up();
        t_count_down();
        t_inhibit();
        t_flags();
        t_load_async();
        t_cascade();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule